// File: doc/BRIEF.md
# Lane-Parallel Squared-Difference Streaming Unit

This unit is a custom streaming operation that sits next to the ALU of a vector processor. It holds one identical arithmetic pipeline per vector lane. Each clock cycle, every lane takes two signed operands, subtracts the second from the first, and squares the difference. After a fixed number of cycles, the lane presents the low word of the square together with a write enable for the scratchpad writeback path.

The host execute stage never stalls. The unit therefore has no ready signal and takes a new element on every cycle in which the valid input is high. Each operation comes with a sideband carrying an operation code and an operand-size code. The unit produces results only when the code equals its own configured value and the size code selects 32-bit words.

A start pulse marks the first element of a new vector operation. It removes every element still in flight from the previous operation, so no stale result reaches writeback. The element presented in the same cycle as the start pulse is kept.

Top module: `lane_sqdiff_unit`

## Requirements
- R1: For each accepted element, a lane's result is the low 32 bits of (A − B)², with A and B taken as 32-bit two's-complement values. The result wraps and does not saturate. For example, A=0x7FFFFFFF and B=0x80000000 give 1, and A=0x00010000 and B=0 give 0.
- R2: Each lane's result depends only on that lane's own operands. Lane i uses bits [32i+31:32i] of a_in, b_in and c_out.
- R3: An element sampled at clock edge k appears on c_out, with wr_en high, directly after edge k+2. The pipeline latency is 3.
- R4: An element is accepted on every cycle in which valid is high, including back-to-back cycles. There is no back-pressure signal.
- R5: wr_en is high only for elements whose valid was high. Bubble cycles produce no write enable.
- R6: An element whose opcode differs from the configured code (default 0) produces no write enable.
- R7: An element whose opsize is not 2 (the code for 32-bit words) produces no write enable.
- R8: A start pulse at edge k discards every element sampled before edge k that has not yet been written back. The element sampled at edge k is still processed normally.
- R9: While reset is asserted, wr_en and c_out are all zero.
- R10: The wr_en bits of all lanes are either all high or all low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Marks the first element of a new operation; removes elements still in flight |
| valid | input | 1 | Qualifies the operands on this cycle |
| opcode | input | OPC_W | Operation code sideband |
| opsize | input | 2 | Operand size code; 2 selects 32-bit words |
| a_in | input | LANES*DW | Minuend, one word per lane |
| b_in | input | LANES*DW | Subtrahend, one word per lane |
| c_out | output | LANES*DW | Squared difference, one word per lane |
| wr_en | output | LANES | Per-lane writeback enable |

## Verification
A wrong bit in the valid pipeline shows at wr_en after at most three cycles. It appears either as a write during a bubble, after a rejected code, or after a start pulse, or as a missing write for an accepted element. The bench's per-cycle model catches this on the exact cycle. A wrong data stage appears on c_out in the cycle that the element's write enable rises. The arithmetic corner values, such as a difference of minus one and differences whose square is a multiple of 2^32, expose subtraction or multiply width errors at once.

// File: rtl/sqd_pkg.sv
package sqd_pkg;
    localparam int SZ_W    = 2;
    localparam logic [SZ_W-1:0] SZ_WORD = 2'd2;
endpackage

// File: rtl/sqd_decode.sv
module sqd_decode #(
    parameter int OPC_W = 2,
    parameter logic [OPC_W-1:0] MY_OP = '0
) (
    input  logic                     valid,
    input  logic [OPC_W-1:0]         opcode,
    input  logic [sqd_pkg::SZ_W-1:0] opsize,
    output logic                     take
);
    logic code_ok;
    logic size_ok;

    always_comb begin
        code_ok = (opcode == MY_OP);
        size_ok = (opsize == sqd_pkg::SZ_WORD);
        take    = valid && code_ok && size_ok;
    end
endmodule

// File: rtl/sqd_ctrl.sv
module sqd_ctrl #(
    parameter int LAT = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic take,
    output logic out_vld
);
    typedef struct packed {
        logic [LAT-1:0] vld;
    } ctrl_t;

    ctrl_t ctrl_d;
    ctrl_t ctrl_q;

    always_comb begin
        ctrl_d     = ctrl_q;
        ctrl_d.vld = {ctrl_q.vld[LAT-2:0], take};
        if (start) begin
            ctrl_d.vld[LAT-1:1] = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    assign out_vld = ctrl_q.vld[LAT-1];
endmodule

// File: rtl/sqd_lane.sv
module sqd_lane #(
    parameter int DW  = 32,
    parameter int LAT = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    output logic [DW-1:0] c
);
    typedef struct packed {
        logic [DW-1:0]            diff;
        logic [LAT-1:1][DW-1:0]   prod;
    } lane_t;

    lane_t lane_d;
    lane_t lane_q;

    always_comb begin
        lane_d         = lane_q;
        lane_d.diff    = a - b;
        lane_d.prod[1] = lane_q.diff * lane_q.diff;
        for (int k = 2; k < LAT; k++) begin
            lane_d.prod[k] = lane_q.prod[k-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lane_q <= '0;
        end else begin
            lane_q <= lane_d;
        end
    end

    assign c = lane_q.prod[LAT-1];
endmodule

// File: rtl/lane_sqdiff_unit.sv
module lane_sqdiff_unit #(
    parameter int LANES = 4,
    parameter int DW    = 32,
    parameter int LAT   = 3,
    parameter int OPC_W = 2,
    parameter logic [OPC_W-1:0] MY_OP = '0
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic                     valid,
    input  logic [OPC_W-1:0]         opcode,
    input  logic [sqd_pkg::SZ_W-1:0] opsize,
    input  logic [LANES*DW-1:0]      a_in,
    input  logic [LANES*DW-1:0]      b_in,
    output logic [LANES*DW-1:0]      c_out,
    output logic [LANES-1:0]         wr_en
);
    localparam int BUS_W = LANES * DW;

    logic take;
    logic out_vld;

    sqd_decode #(.OPC_W(OPC_W), .MY_OP(MY_OP)) u_decode (
        .valid  (valid),
        .opcode (opcode),
        .opsize (opsize),
        .take   (take)
    );

    sqd_ctrl #(.LAT(LAT)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .take    (take),
        .out_vld (out_vld)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        sqd_lane #(.DW(DW), .LAT(LAT)) u_lane (
            .clk   (clk),
            .rst_n (rst_n),
            .a     (a_in[g*DW +: DW]),
            .b     (b_in[g*DW +: DW]),
            .c     (c_out[g*DW +: DW])
        );
    end

    assign wr_en = {LANES{out_vld}};

    logic [BUS_W-1:0] unused_bus;
    assign unused_bus = '0;
endmodule

// File: rtl/sqd_checker.sv
module sqd_checker #(
    parameter int LANES = 4,
    parameter int DW    = 32,
    parameter int LAT   = 3,
    parameter int OPC_W = 2,
    parameter logic [OPC_W-1:0] MY_OP = '0
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     start,
    input logic                     valid,
    input logic [OPC_W-1:0]         opcode,
    input logic [sqd_pkg::SZ_W-1:0] opsize,
    input logic [LANES*DW-1:0]      a_in,
    input logic [LANES*DW-1:0]      b_in,
    input logic [LANES*DW-1:0]      c_out,
    input logic [LANES-1:0]         wr_en
);
    localparam int CW = $clog2(LAT + 1);
    localparam logic [CW-1:0] WARM = CW'(LAT);

    logic [CW-1:0] since_rst;
    logic          warm;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_rst <= '0;
        end else if (since_rst != WARM) begin
            since_rst <= since_rst + 1'b1;
        end
    end
    assign warm = (since_rst == WARM);

    AST_LANES_AGREE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en == '0) || (wr_en == '1)); // R10

    AST_WRITE_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && wr_en[0]) |-> $past(valid, LAT)); // R5

    AST_WRITE_NEEDS_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && wr_en[0]) |-> ($past(opcode, LAT) == MY_OP)); // R6

    AST_WRITE_NEEDS_SIZE: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && wr_en[0]) |-> ($past(opsize, LAT) == sqd_pkg::SZ_WORD)); // R7

    AST_LANE0_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && wr_en[0]) |-> (c_out[DW-1:0] ==
            DW'(($past(a_in[DW-1:0], LAT) - $past(b_in[DW-1:0], LAT)) *
                ($past(a_in[DW-1:0], LAT) - $past(b_in[DW-1:0], LAT))))); // R3

    for (genvar j = 1; j < LAT; j++) begin : g_flush
        AST_NO_STALE_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
            (warm && wr_en[0]) |-> !$past(start, j)); // R8
    end
endmodule

bind lane_sqdiff_unit sqd_checker #(
    .LANES(LANES), .DW(DW), .LAT(LAT), .OPC_W(OPC_W), .MY_OP(MY_OP)
) u_sqd_checker (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .valid  (valid),
    .opcode (opcode),
    .opsize (opsize),
    .a_in   (a_in),
    .b_in   (b_in),
    .c_out  (c_out),
    .wr_en  (wr_en)
);

// File: tb/test_lane_sqdiff_unit.sv
`timescale 1ns/1ps
module test_lane_sqdiff_unit;
    localparam int LANES = 4;
    localparam int DW    = 32;
    localparam int LAT   = 3;
    localparam int OPC_W = 2;

    logic                   clk = 1'b0;
    logic                   rst_n = 1'b0;
    logic                   start = 1'b0;
    logic                   valid = 1'b0;
    logic [OPC_W-1:0]       opcode = '0;
    logic [1:0]             opsize = 2'd2;
    logic [LANES*DW-1:0]    a_in = '0;
    logic [LANES*DW-1:0]    b_in = '0;
    logic [LANES*DW-1:0]    c_out;
    logic [LANES-1:0]       wr_en;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit run = 1'b0;
    string phase = "R9";

    typedef struct {
        int                  due;
        logic [LANES*DW-1:0] res;
    } pend_t;
    pend_t pending[$];

    always #2.5 clk = ~clk;

    lane_sqdiff_unit #(.LANES(LANES), .DW(DW), .LAT(LAT), .OPC_W(OPC_W)) i_lane_sqdiff_unit (
        .clk(clk), .rst_n(rst_n), .start(start), .valid(valid),
        .opcode(opcode), .opsize(opsize), .a_in(a_in), .b_in(b_in),
        .c_out(c_out), .wr_en(wr_en)
    );

    task automatic check(input bit ok, input string req, input logic [LANES*DW-1:0] act,
                         input logic [LANES*DW-1:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s (phase %s) cycle %0d: actual=%h expected=%h", req, phase, cyc, act, exp);
        end
    endtask

    // reference model: queue of expected write-backs, keyed by due cycle
    always @(posedge clk) begin
        if (!rst_n) begin
            cyc = 0;
            pending.delete();
        end else begin
            cyc++;
            if (start) pending.delete();
            if (valid && opcode == '0 && opsize == 2'd2) begin
                pend_t p;
                p.due = cyc + LAT - 1;
                for (int i = 0; i < LANES; i++) begin
                    logic [DW-1:0] d;
                    d = a_in[i*DW +: DW] - b_in[i*DW +: DW];
                    p.res[i*DW +: DW] = d * d;
                end
                pending.push_back(p);
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n && run) begin
            if (wr_en != '0 && wr_en != '1)
                check(1'b0, "R10", {{(LANES*DW-LANES){1'b0}}, wr_en}, '0);
            if (pending.size() > 0 && pending[0].due == cyc) begin
                check(wr_en == '1, "R3 R4",
                      {{(LANES*DW-LANES){1'b0}}, wr_en}, {{(LANES*DW-LANES){1'b0}}, {LANES{1'b1}}});
                check(c_out == pending[0].res, "R1 R2", c_out, pending[0].res);
                void'(pending.pop_front());
            end else begin
                check(wr_en == '0, "R5 R6 R7 R8",
                      {{(LANES*DW-LANES){1'b0}}, wr_en}, '0);
            end
        end
    end

    task automatic drive(input bit st, input bit v, input logic [OPC_W-1:0] op,
                         input logic [1:0] sz);
        @(negedge clk);
        start  = st;
        valid  = v;
        opcode = op;
        opsize = sz;
        for (int i = 0; i < LANES; i++) begin
            a_in[i*DW +: DW] = $urandom();
            b_in[i*DW +: DW] = $urandom();
        end
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired in phase %s", phase);
        summary();
    end

    initial begin
        // R9: reset state
        repeat (3) @(negedge clk);
        check(wr_en == '0, "R9", {{(LANES*DW-LANES){1'b0}}, wr_en}, '0);
        check(c_out == '0, "R9", c_out, '0);
        rst_n = 1'b1;
        run = 1'b1;

        // R1 R2: arithmetic corners, a different one per lane
        phase = "R1";
        @(negedge clk);
        start = 1'b1; valid = 1'b1; opcode = '0; opsize = 2'd2;
        a_in = {32'h0001_0000, 32'hFFFF_FFFD, 32'h0000_0005, 32'h7FFF_FFFF};
        b_in = {32'h0000_0000, 32'h0000_0004, 32'h0000_0005, 32'h8000_0000};
        @(negedge clk);
        start = 1'b0;
        a_in = {32'h8000_0000, 32'h0000_0000, 32'hFFFF_FFFF, 32'h0000_0003};
        b_in = {32'h0000_0000, 32'h0001_0000, 32'h0000_0001, 32'hFFFF_FFFE};
        @(negedge clk);
        valid = 1'b0;
        repeat (LAT + 1) @(negedge clk);

        // R4: back-to-back stream
        phase = "R4";
        drive(1'b1, 1'b1, '0, 2'd2);
        repeat (20) drive(1'b0, 1'b1, '0, 2'd2);

        // R5: bubbles
        phase = "R5";
        for (int n = 0; n < 16; n++) drive(1'b0, n[0], '0, 2'd2);

        // R6: foreign codes
        phase = "R6";
        for (int n = 0; n < 16; n++) drive(1'b0, 1'b1, OPC_W'(n % 4), 2'd2);

        // R7: other sizes
        phase = "R7";
        for (int n = 0; n < 16; n++) drive(1'b0, 1'b1, '0, 2'(n));

        // R8: start mid-stream removes in-flight elements
        phase = "R8";
        repeat (5) drive(1'b0, 1'b1, '0, 2'd2);
        drive(1'b1, 1'b1, '0, 2'd2);
        repeat (4) drive(1'b0, 1'b1, '0, 2'd2);
        drive(1'b1, 1'b0, '0, 2'd2);
        repeat (LAT + 1) drive(1'b0, 1'b0, '0, 2'd2);

        // mixed traffic
        phase = "mix";
        for (int n = 0; n < 400; n++)
            drive(($urandom_range(0, 9) == 0), ($urandom_range(0, 9) < 7),
                  (($urandom_range(0, 4) == 0) ? OPC_W'($urandom_range(1, 3)) : '0),
                  (($urandom_range(0, 5) == 0) ? 2'($urandom_range(0, 3)) : 2'd2));
        repeat (LAT + 2) drive(1'b0, 1'b0, '0, 2'd2);
        summary();
    end
endmodule